// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Vector Generator

This block sits between a processor's interrupt acknowledge strobe and a pair of 8-line interrupt controllers. The two controllers are chained: the downstream ("slave") controller's request output drives request line 2 of the upstream ("master") controller, and only the master's output reaches the processor. When the processor acknowledges, the block takes the pending-line result from each controller. It decides which controller or controllers must see an acknowledge, sends them single-cycle acknowledge pulses with the line number to retire, and produces the 8-bit vector number the processor will use.

Each controller reports a pending flag, a 3-bit line number and a vector base. The base's low three bits are ignored, so the vector is the base with the line number placed in its low bits. If the controller that was consulted last has nothing pending, the event is spurious. In that case the vector points at line 7 of that controller and the spurious flag is raised. The acknowledge pulses are combinational in the strobe cycle. The vector, the spurious flag and a valid pulse are registered and appear one clock after the strobe.

Top module: `cascade_ack_vec`

## Requirements
- R1: If the master reports nothing pending during an acknowledge strobe, neither controller is acknowledged. One cycle later the vector is master base with low bits 3'b111, and the spurious flag is 1.
- R2: If the master reports a line other than 2, the master acknowledge pulses with that line in the strobe cycle, and the slave is not acknowledged. One cycle later the vector is master base with that line in bits 2:0, and the spurious flag is 0.
- R3: If the master reports line 2 and the slave reports a line, both acknowledges pulse in the strobe cycle: the master with line 2 and the slave with its own line. One cycle later the vector is slave base with the slave line in bits 2:0, and the spurious flag is 0.
- R4: If the master reports line 2 and the slave has nothing pending, only the master acknowledge pulses (line 2). One cycle later the vector is slave base with bits 2:0 = 3'b111, and the spurious flag is 1.
- R5: Bits 2:0 of either vector base have no effect on the vector.
- R6: The valid output is high in exactly the cycle after each strobe cycle. Vector and spurious flag change only in that cycle and otherwise hold their value.
- R7: No acknowledge pulse is issued in a cycle without an acknowledge strobe.
- R8: While synchronous reset is high and after it, until the first strobe, valid, vector and spurious flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inta_i | input | 1 | Processor acknowledge strobe, one cycle per acknowledge |
| m_pend_i | input | 1 | Master has a pending line |
| m_line_i | input | 3 | Master pending line number |
| m_base_i | input | 8 | Master vector base (bits 2:0 ignored) |
| s_pend_i | input | 1 | Slave has a pending line |
| s_line_i | input | 3 | Slave pending line number |
| s_base_i | input | 8 | Slave vector base (bits 2:0 ignored) |
| m_ack_o | output | 1 | Acknowledge pulse to master |
| m_ack_line_o | output | 3 | Line the master must retire |
| s_ack_o | output | 1 | Acknowledge pulse to slave |
| s_ack_line_o | output | 3 | Line the slave must retire |
| vec_vld_o | output | 1 | Vector valid pulse, one cycle after strobe |
| vec_o | output | 8 | Vector number |
| spur_o | output | 1 | Acknowledge was spurious |

## Verification
The bench targets the cascade line against its neighbours, lines 1 and 3. A design that compares the wrong line would route a normal master interrupt through the slave, or the reverse. It drives the two spurious paths and checks that the line-7 vector uses the correct controller's base. Swapping the bases there gives a vector off by the difference between the bases. It also checks that the slave-spurious case still acknowledges the master and never the slave. The bench puts non-zero low bits in both bases to expose a missing mask, and it runs strobes in consecutive cycles and with gaps, so that a vector that changes without a strobe or a valid pulse that is late or stretched shows up against the reference model.

// File: rtl/cav_pkg.sv
package cav_pkg;
  // Outcome of one acknowledge decision
  typedef enum logic [1:0] {
    CAV_MASTER = 2'd0,
    CAV_SLAVE  = 2'd1,
    CAV_SPUR_M = 2'd2,
    CAV_SPUR_S = 2'd3
  } cav_kind_e;
endpackage

// File: rtl/cav_resolve.sv
module cav_resolve
  import cav_pkg::*;
#(
  parameter int LINE_W    = 3,
  parameter int VEC_W     = 8,
  parameter int CASC_LINE = 2
) (
  input  logic              m_pend,
  input  logic [LINE_W-1:0] m_line,
  input  logic [VEC_W-1:0]  m_base,
  input  logic              s_pend,
  input  logic [LINE_W-1:0] s_line,
  input  logic [VEC_W-1:0]  s_base,
  output cav_kind_e         kind,
  output logic [VEC_W-1:0]  vec
);
  localparam logic [VEC_W-1:0]  BASE_MASK = {{(VEC_W-LINE_W){1'b1}}, {LINE_W{1'b0}}};
  localparam logic [LINE_W-1:0] SPUR_LINE = {LINE_W{1'b1}};
  localparam logic [LINE_W-1:0] CASC     = LINE_W'(CASC_LINE);

  logic [VEC_W-1:0]  sel_base;
  logic [LINE_W-1:0] sel_line;

  always_comb begin
    if (!m_pend)               kind = CAV_SPUR_M;
    else if (m_line != CASC)   kind = CAV_MASTER;
    else if (s_pend)           kind = CAV_SLAVE;
    else                       kind = CAV_SPUR_S;
  end

  always_comb begin
    unique case (kind)
      CAV_MASTER: begin sel_base = m_base; sel_line = m_line;    end
      CAV_SLAVE:  begin sel_base = s_base; sel_line = s_line;    end
      CAV_SPUR_S: begin sel_base = s_base; sel_line = SPUR_LINE; end
      default:    begin sel_base = m_base; sel_line = SPUR_LINE; end
    endcase
    vec = (sel_base & BASE_MASK) | {{(VEC_W-LINE_W){1'b0}}, sel_line};
  end
endmodule

// File: rtl/cav_out_reg.sv
module cav_out_reg #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [VEC_W-1:0] vec_d,
  input  logic             spur_d,
  output logic             vld_q,
  output logic [VEC_W-1:0] vec_q,
  output logic             spur_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      vec_q  <= '0;
      spur_q <= 1'b0;
    end else begin
      vld_q <= load;
      if (load) begin
        vec_q  <= vec_d;
        spur_q <= spur_d;
      end
    end
  end
endmodule

// File: rtl/cascade_ack_vec.sv
module cascade_ack_vec
  import cav_pkg::*;
#(
  parameter int LINE_W    = 3,
  parameter int VEC_W     = 8,
  parameter int CASC_LINE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inta_i,
  input  logic              m_pend_i,
  input  logic [LINE_W-1:0] m_line_i,
  input  logic [VEC_W-1:0]  m_base_i,
  input  logic              s_pend_i,
  input  logic [LINE_W-1:0] s_line_i,
  input  logic [VEC_W-1:0]  s_base_i,
  output logic              m_ack_o,
  output logic [LINE_W-1:0] m_ack_line_o,
  output logic              s_ack_o,
  output logic [LINE_W-1:0] s_ack_line_o,
  output logic              vec_vld_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              spur_o
);
  localparam logic [LINE_W-1:0] SPUR_LINE = {LINE_W{1'b1}};

  cav_kind_e        kind;
  logic [VEC_W-1:0] vec_n;

  cav_resolve #(.LINE_W(LINE_W), .VEC_W(VEC_W), .CASC_LINE(CASC_LINE)) u_resolve (
    .m_pend (m_pend_i), .m_line (m_line_i), .m_base (m_base_i),
    .s_pend (s_pend_i), .s_line (s_line_i), .s_base (s_base_i),
    .kind   (kind),     .vec    (vec_n)
  );

  // Acknowledge pulses in the strobe cycle
  assign m_ack_o      = inta_i && (kind != CAV_SPUR_M);
  assign m_ack_line_o = m_line_i;
  assign s_ack_o      = inta_i && (kind == CAV_SLAVE);
  assign s_ack_line_o = s_line_i;

  cav_out_reg #(.VEC_W(VEC_W)) u_out (
    .clk    (clk),
    .rst    (rst),
    .load   (inta_i),
    .vec_d  (vec_n),
    .spur_d (kind == CAV_SPUR_M || kind == CAV_SPUR_S),
    .vld_q  (vec_vld_o),
    .vec_q  (vec_o),
    .spur_q (spur_o)
  );

  // R7: acknowledges only while strobed
  a_r7_no_ack_idle: assert property (@(posedge clk) disable iff (rst)
    !inta_i |-> (!m_ack_o && !s_ack_o));
  // R6: valid exactly one cycle after a strobe
  a_r6_vld_after_strobe: assert property (@(posedge clk) disable iff (rst)
    inta_i |=> vec_vld_o);
  a_r6_no_vld_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !inta_i |=> (!vec_vld_o && $stable(vec_o) && $stable(spur_o)));
  // R3: slave is acknowledged only through the cascade line of the master
  a_r3_slave_via_cascade: assert property (@(posedge clk) disable iff (rst)
    s_ack_o |-> (m_ack_o && m_ack_line_o == LINE_W'(CASC_LINE)));
  // R1/R4: a spurious vector always points at the top line
  a_r1_spur_line: assert property (@(posedge clk) disable iff (rst)
    (vec_vld_o && spur_o) |-> (vec_o[LINE_W-1:0] == SPUR_LINE));
  // R1: no master pending means no acknowledge at all
  a_r1_no_ack_when_idle: assert property (@(posedge clk) disable iff (rst)
    (inta_i && !m_pend_i) |-> (!m_ack_o && !s_ack_o));
endmodule

// File: tb/cascade_ack_vec_tb.sv
module cascade_ack_vec_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       inta;
  logic       mp, sp;
  logic [2:0] ml, sl;
  logic [7:0] mb, sb;
  logic       m_ack, s_ack, vld, spur;
  logic [2:0] m_al, s_al;
  logic [7:0] vec;

  int n_chk = 0, n_fail = 0;

  // reference registered state
  bit       e_vld = 0, e_spur = 0;
  int       e_vec = 0;

  always #4 clk = ~clk;

  cascade_ack_vec u_dut (
    .clk(clk), .rst(rst), .inta_i(inta),
    .m_pend_i(mp), .m_line_i(ml), .m_base_i(mb),
    .s_pend_i(sp), .s_line_i(sl), .s_base_i(sb),
    .m_ack_o(m_ack), .m_ack_line_o(m_al), .s_ack_o(s_ack), .s_ack_line_o(s_al),
    .vec_vld_o(vld), .vec_o(vec), .spur_o(spur)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare, then let the posedge happen
  task automatic step(input bit a, input bit p_m, input int l_m, input int b_m,
                      input bit p_s, input int l_s, input int b_s, input string req);
    bit xm, xs, xspur;
    int xvec;
    @(negedge clk);
    inta = a; mp = p_m; ml = 3'(l_m); mb = 8'(b_m);
    sp = p_s; sl = 3'(l_s); sb = 8'(b_s);
    #1;
    // registered outputs reflect the previous step
    chk({req, " R6 vld"}, int'(vld), int'(e_vld));
    chk({req, " R6 vec"}, int'(vec), e_vec);
    chk({req, " R6 spur"}, int'(spur), int'(e_spur));
    // reference decision
    xm = 0; xs = 0; xspur = 0;
    if (!p_m) begin xspur = 1; xvec = (b_m / 8) * 8 + 7; end
    else if (l_m != 2) begin xm = 1; xvec = (b_m / 8) * 8 + l_m; end
    else if (p_s) begin xm = 1; xs = 1; xvec = (b_s / 8) * 8 + l_s; end
    else begin xm = 1; xspur = 1; xvec = (b_s / 8) * 8 + 7; end
    chk({req, " m_ack"}, int'(m_ack), a ? int'(xm) : 0);
    chk({req, " s_ack"}, int'(s_ack), a ? int'(xs) : 0);
    if (a && xm) chk({req, " m_ack_line"}, int'(m_al), l_m);
    if (a && xs) chk({req, " s_ack_line"}, int'(s_al), l_s);
    e_vld = a;
    if (a) begin e_vec = xvec; e_spur = xspur; end
  endtask

  initial begin
    #150000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1; inta = 0; mp = 0; ml = 0; mb = 0; sp = 0; sl = 0; sb = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    chk("R8 vld", int'(vld), 0);
    chk("R8 vec", int'(vec), 0);
    chk("R8 spur", int'(spur), 0);
    rst = 0;
    step(0, 1, 5, 8'h20, 1, 3, 8'h70, "R7 idle");
    step(0, 0, 0, 8'h20, 0, 0, 8'h70, "R8 post");
    step(1, 0, 4, 8'h25, 1, 1, 8'h73, "R1");       // master idle -> 0x27
    step(1, 1, 1, 8'h08, 0, 0, 8'h70, "R2 l1");
    step(1, 1, 3, 8'h0F, 1, 6, 8'h70, "R2 l3 R5");
    step(1, 1, 2, 8'h20, 1, 5, 8'h77, "R3 R5");    // 0x75
    step(1, 1, 2, 8'h20, 0, 5, 8'h7A, "R4 R5");    // 0x7F
    step(0, 1, 0, 8'h30, 1, 0, 8'h50, "R6 gap");
    step(0, 1, 0, 8'h31, 1, 0, 8'h51, "R6 hold");
    step(1, 1, 7, 8'hF8, 1, 0, 8'h00, "R2 l7");
    step(1, 1, 2, 8'h00, 1, 0, 8'hFF, "R3 l0");
    step(1, 1, 0, 8'hC0, 0, 0, 8'h00, "R2 l0");
    for (int i = 0; i < 400; i++)
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0),
           (($urandom_range(0, 2) == 0) ? 2 : int'($urandom_range(0, 7))),
           int'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
           int'($urandom_range(0, 7)), int'($urandom_range(0, 255)), "rand");
    step(0, 0, 0, 0, 0, 0, 0, "tail");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule